// File: doc/BRIEF.md
# Binary Search Tree Sorter

This block sorts a batch of unsigned integers by building a binary search tree in on-chip node memory and then walking that tree in order. Each node carries a left link, a right link, an occurrence count and a value. A value that is already in the tree only raises that node's count, so the output lists each distinct value once, in ascending order, together with the number of times it arrived.

Values arrive on a valid/ready stream. The input side accepts a value only while it is idle. Each insertion descends from the root, one node comparison per read, and the stream stalls until that insertion is finished. A single-cycle end strobe closes the batch. The traversal is a recursive procedure run by a hierarchical state machine. Each call pushes its node and return point on a dedicated return stack, and each return pops them. Pairs leave on a valid/ready stream that honours back-pressure, and a one-cycle done pulse follows the last pair. The tree is then emptied for the next batch.

Top module: `bst_sorter`

## Requirements
- R1: After reset, in_ready is 1 and out_valid, out_done and overflow are 0.
- R2: After in_end, the block emits each distinct stored value exactly once, in strictly ascending order.
- R3: The out_count sent with a value equals the number of times that value was accepted in the batch.
- R4: A count saturates at 2^CW-1 (255 by default). Further copies leave it at that value.
- R5: The tree holds DEPTH distinct values. A new distinct value that arrives when the tree is full is dropped and overflow goes to 1. Copies of values already stored are still counted. overflow stays 0 in a batch that never overflows.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_value and out_count stay unchanged. No pair is lost or repeated.
- R7: out_done is a one-cycle pulse that follows the last accepted pair. In the next cycle in_ready is 1 and overflow is 0, and the next batch starts with an empty tree.
- R8: An in_end with no values accepted produces no pair, only the done pulse.
- R9: in_ready is 0 from the end strobe until the done pulse, so no value is taken while pairs are being sent. in_end is sampled only while in_ready is 1 and in_valid is 0.
- R10: A list-shaped tree of DEPTH nodes, built from strictly ascending or strictly descending input, is output correctly with no stack overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input value offered |
| in_ready | output | 1 | Block can accept a value or the end strobe |
| in_value | input | VW | Value to insert |
| in_end | input | 1 | End of batch strobe |
| out_valid | output | 1 | Sorted pair present |
| out_ready | input | 1 | Consumer takes the pair |
| out_value | output | VW | Distinct value |
| out_count | output | CW | Occurrences of out_value |
| out_done | output | 1 | One-cycle pulse after the last pair |
| overflow | output | 1 | A distinct value was dropped in this batch |

## Verification
The assertions check four things on every cycle: the output holds steady under back-pressure, accepted values rise strictly, counts are never zero, and output never overlaps input acceptance. They also check that the return stack is never pushed when full or popped when empty, and that the done pulse is followed by an idle, cleared block. Only the bench scenarios can show that the whole set of pairs matches the input multiset. The same holds for saturating counts, for dropping exactly the values that arrive once the tree is full, for the empty batch, and for list-shaped trees in both directions.

// File: rtl/bst_pkg.sv
package bst_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_INS_WAIT, S_INS_CMP, S_INS_ALLOC,
    T_ENTER, T_RDW, T_DESC, T_RETURN, T_EWAIT, T_EMIT, S_DONE
  } st_t;

  // return point stored with each stack frame
  typedef enum logic {RET_EMIT = 1'b0, RET_FINISH = 1'b1} ret_t;
endpackage

// File: rtl/bst_node_ram.sv
module bst_node_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = 7,
  parameter int NW    = 38
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [NW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [NW-1:0] rdata
);
  logic [NW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && waddr < AW'(DEPTH)) mem[waddr] <= wdata;
    rdata <= (raddr < AW'(DEPTH)) ? mem[raddr] : '0;
  end

  a_r5_waddr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> waddr < AW'(DEPTH));
endmodule

// File: rtl/bst_ret_stack.sv
module bst_ret_stack #(
  parameter int DEPTH = 64,
  parameter int EW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [EW-1:0] din,
  output logic [EW-1:0] top,
  output logic          empty,
  output logic          full
);
  localparam int SPW = $clog2(DEPTH + 1);
  logic [EW-1:0]  mem [DEPTH];
  logic [SPW-1:0] sp;

  assign empty = (sp == '0);
  assign full  = (sp == SPW'(DEPTH));
  assign top   = empty ? '0 : mem[sp - SPW'(1)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp <= '0;
    else if (push && !full) sp <= sp + SPW'(1);
    else if (pop && !empty) sp <= sp - SPW'(1);
  end

  always_ff @(posedge clk)
    if (push && !full) mem[sp] <= din;

  a_r10_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r10_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r10_no_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/bst_sorter.sv
module bst_sorter
  import bst_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int VW    = 16,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [VW-1:0] in_value,
  input  logic          in_end,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VW-1:0] out_value,
  output logic [CW-1:0] out_count,
  output logic          out_done,
  output logic          overflow
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int NW = 2 * PW + CW + VW;
  localparam int EW = PW + 1;
  localparam logic [PW-1:0] NULLP = '1;
  localparam logic [CW-1:0] CMAX  = '1;

  st_t           st;
  logic [PW-1:0] cur, used, nxt;
  logic [VW-1:0] key;
  logic          ovf;

  logic          we;
  logic [PW-1:0] waddr;
  logic [NW-1:0] wdata, q;
  logic          push, pop, s_empty, s_full;
  logic [EW-1:0] s_din, s_top;

  logic [PW-1:0] q_l, q_r;
  logic [CW-1:0] q_c;
  logic [VW-1:0] q_v;
  assign q_l = q[NW-1 -: PW];
  assign q_r = q[NW-1-PW -: PW];
  assign q_c = q[VW+CW-1 -: CW];
  assign q_v = q[VW-1:0];

  logic tree_full;
  assign tree_full = (used == PW'(DEPTH));
  assign nxt = (key < q_v) ? q_l : q_r;

  function automatic logic [NW-1:0] mk_node(logic [PW-1:0] l, logic [PW-1:0] r,
                                            logic [CW-1:0] c, logic [VW-1:0] v);
    return {l, r, c, v};
  endfunction

  bst_node_ram #(.DEPTH(DEPTH), .AW(PW), .NW(NW)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(cur), .rdata(q));

  bst_ret_stack #(.DEPTH(DEPTH), .EW(EW)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(s_din),
    .top(s_top), .empty(s_empty), .full(s_full));

  always_comb begin
    we    = 1'b0;
    waddr = cur;
    wdata = q;
    push  = 1'b0;
    pop   = 1'b0;
    s_din = {cur, RET_EMIT};
    case (st)
      S_IDLE: if (in_valid && used == '0) begin
        we    = 1'b1;
        waddr = '0;
        wdata = mk_node(NULLP, NULLP, CW'(1), in_value);
      end
      S_INS_CMP:
        if (key == q_v) begin
          we    = (q_c != CMAX);
          wdata = mk_node(q_l, q_r, q_c + CW'(1), q_v);
        end else if (nxt == NULLP && !tree_full) begin
          we    = 1'b1;
          wdata = (key < q_v) ? mk_node(used, q_r, q_c, q_v)
                              : mk_node(q_l, used, q_c, q_v);
        end
      S_INS_ALLOC: begin
        we    = 1'b1;
        waddr = used;
        wdata = mk_node(NULLP, NULLP, CW'(1), key);
      end
      T_DESC: push = 1'b1;
      T_RETURN: pop = !s_empty;
      T_EMIT: if (out_ready) begin
        push  = 1'b1;
        s_din = {cur, RET_FINISH};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cur  <= '0;
      used <= '0;
      key  <= '0;
      ovf  <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (in_valid) begin
            key <= in_value;
            if (used == '0) used <= PW'(1);
            else begin
              cur <= '0;
              st  <= S_INS_WAIT;
            end
          end else if (in_end) begin
            cur <= (used == '0) ? NULLP : '0;
            st  <= T_ENTER;
          end
        S_INS_WAIT: st <= S_INS_CMP;
        S_INS_CMP:
          if (key == q_v) st <= S_IDLE;
          else if (nxt != NULLP) begin
            cur <= nxt;
            st  <= S_INS_WAIT;
          end else if (tree_full) begin
            ovf <= 1'b1;
            st  <= S_IDLE;
          end else st <= S_INS_ALLOC;
        S_INS_ALLOC: begin
          used <= used + PW'(1);
          st   <= S_IDLE;
        end
        T_ENTER: st <= (cur == NULLP) ? T_RETURN : T_RDW;
        T_RDW:   st <= T_DESC;
        T_DESC: begin
          cur <= q_l;
          st  <= T_ENTER;
        end
        T_RETURN:
          if (s_empty) st <= S_DONE;
          else begin
            cur <= s_top[EW-1:1];
            st  <= (s_top[0] == RET_EMIT) ? T_EWAIT : T_RETURN;
          end
        T_EWAIT: st <= T_EMIT;
        T_EMIT: if (out_ready) begin
          cur <= q_r;
          st  <= T_ENTER;
        end
        S_DONE: begin
          used <= '0;
          ovf  <= 1'b0;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign in_ready  = (st == S_IDLE);
  assign out_valid = (st == T_EMIT);
  assign out_value = q_v;
  assign out_count = q_c;
  assign out_done  = (st == S_DONE);
  assign overflow  = ovf;

  // checker state: last value handed over in this batch
  logic [VW-1:0] chk_prev;
  logic          chk_have;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_prev <= '0;
      chk_have <= 1'b0;
    end else if (out_done) chk_have <= 1'b0;
    else if (out_valid && out_ready) begin
      chk_prev <= out_value;
      chk_have <= 1'b1;
    end
  end

  a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && chk_have |-> out_value > chk_prev);
  a_r3_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_count != '0);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_value) && $stable(out_count));
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done && in_ready && !overflow);
endmodule

// File: tb/sim_bst_sorter.sv
`timescale 1ns/1ps
module sim_bst_sorter;
  localparam int DEPTH = 64;
  localparam int VW = 16;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_end = 1'b0, out_ready = 1'b0;
  logic [VW-1:0] in_value = '0;
  logic in_ready, out_valid, out_done, overflow;
  logic [VW-1:0] out_value;
  logic [CW-1:0] out_count;

  always #2 clk = ~clk;

  bst_sorter #(.DEPTH(DEPTH), .VW(VW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_end(in_end), .out_valid(out_valid),
    .out_ready(out_ready), .out_value(out_value), .out_count(out_count),
    .out_done(out_done), .overflow(overflow));

  int n_chk = 0, n_err = 0;
  int m_v[DEPTH], m_c[DEPTH], m_n;
  bit m_ovf;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic m_add(input int v);
    for (int i = 0; i < m_n; i++)
      if (m_v[i] == v) begin
        if (m_c[i] < CMAX) m_c[i]++;
        return;
      end
    if (m_n < DEPTH) begin
      m_v[m_n] = v;
      m_c[m_n] = 1;
      m_n++;
    end else m_ovf = 1'b1;
  endtask

  task automatic m_sort();
    for (int i = 0; i < m_n; i++)
      for (int j = 0; j + 1 < m_n - i; j++)
        if (m_v[j] > m_v[j+1]) begin
          int tv = m_v[j], tc = m_c[j];
          m_v[j] = m_v[j+1]; m_c[j] = m_c[j+1];
          m_v[j+1] = tv; m_c[j+1] = tc;
        end
  endtask

  task automatic send(input int v);
    @(negedge clk);
    in_valid = 1'b1;
    in_value = VW'(v);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic run_batch(input int vals[$], input int rdy_pct, input string tag);
    int k = 0;
    bit held = 0, fin = 0;
    logic [VW-1:0] hv;
    logic [CW-1:0] hc;
    m_n = 0;
    m_ovf = 1'b0;
    foreach (vals[i]) begin
      send(vals[i]);
      m_add(vals[i]);
    end
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    check(overflow == m_ovf, {tag, " R5 overflow flag"}, overflow, m_ovf);
    in_end = 1'b1;
    @(negedge clk);
    in_end = 1'b0;
    check(!in_ready, {tag, " R9 in_ready low after end"}, in_ready, 0);
    m_sort();
    while (!fin) begin
      @(negedge clk);
      out_ready = ($urandom_range(99) < rdy_pct);
      if (held)
        check(out_valid && out_value == hv && out_count == hc,
              {tag, " R6 held pair stable"}, out_value, hv);
      held = 0;
      if (out_done) fin = 1;
      else if (out_valid) begin
        if (in_ready) check(0, {tag, " R9 in_ready during output"}, 1, 0);
        if (out_ready) begin
          if (k < m_n) begin
            check(out_value == VW'(m_v[k]), {tag, " R2 value order"}, out_value, m_v[k]);
            check(out_count == CW'(m_c[k]), {tag, " R3 count"}, out_count, m_c[k]);
          end else check(0, {tag, " R2 extra pair"}, out_value, -1);
          k++;
        end else begin
          held = 1; hv = out_value; hc = out_count;
        end
      end
    end
    out_ready = 1'b0;
    check(k == m_n, {tag, " R2 pair total"}, k, m_n);
    @(negedge clk);
    check(!out_done && in_ready && !overflow, {tag, " R7 after done"}, out_done, 0);
  endtask

  initial begin
    int q[$];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(in_ready && !out_valid && !out_done && !overflow, "R1 reset state",
          {in_ready, out_valid, out_done, overflow}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !out_valid && !out_done && !overflow, "R1 after release", in_ready, 1);

    q = '{5, 3, 8, 3, 5, 5, 1};
    run_batch(q, 100, "directed R2 R3");

    q = {};
    run_batch(q, 100, "empty R8");

    q = {};
    for (int i = 0; i < 40; i++) q.push_back($urandom_range(31));
    run_batch(q, 60, "random dup R3 R6");

    q = {};
    for (int i = 0; i < 50; i++) q.push_back($urandom_range(65535));
    run_batch(q, 40, "random wide R2 R6");

    q = {};
    for (int i = 0; i < 300; i++) q.push_back(7);
    q.push_back(9);
    run_batch(q, 100, "saturate R4");

    q = {};
    for (int i = 0; i < 70; i++) q.push_back((i * 37 + 11) & 16'hffff);
    for (int i = 0; i < 5; i++) q.push_back((i * 37 + 11) & 16'hffff);
    run_batch(q, 80, "full R5");

    q = {};
    for (int i = 0; i < DEPTH; i++) q.push_back(i * 3);
    run_batch(q, 100, "ascending list R10");

    q = {};
    for (int i = 0; i < DEPTH; i++) q.push_back(60000 - i);
    run_batch(q, 50, "descending list R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R2 act=%0d exp=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule